// File: doc/BRIEF.md
# Timed Pin Command Executor

This block executes one command word at a time against a bank of 32 output lines and 32 input lines. A command is a 52-bit word presented with a one-cycle valid strobe. Depending on its operation code, the executor does one of four things. It can raise one output line for a programmed number of cycles, either at once or after a one-second delay. It can sample one input line after a programmed delay. It can scatter an 8-bit value onto eight independently chosen output lines, either for one cycle or, after a one-second delay, for one second. It can gather eight independently chosen input lines into a byte in a single cycle.

A "second" is `CLKS_PER_SEC` clock cycles, so the same design runs at any clock rate and can be shortened for simulation. While a command is executing, `busy` is high and any new command is discarded. Read results appear on `res_data` with a one-cycle `res_valid` pulse.

Top module: `pin_cmd_exec`

## Requirements
- R1: After reset, `pin_out` is all zero and `busy` and `res_valid` are low.
- R2: Opcode 000 (bits [51:49]) with a nonzero count N in bits [43:0] drives the line selected by bits [48:44] high for exactly N cycles, beginning in the cycle after acceptance. All other lines stay 0, and `busy` is high for the same N cycles.
- R3: Opcode 001 with a nonzero count N keeps every line at 0 for `CLKS_PER_SEC` cycles after acceptance. It then drives the selected line high for N cycles, and `busy` stays high throughout.
- R4: Opcode 100 with delay D in bits [43:0] produces one `res_valid` cycle, D+1 cycles after the acceptance cycle. In that cycle `res_data[0]` is the input line chosen by bits [48:44] and `res_data[7:1]` is 0.
- R5: Opcode 011 drives a byte value (bits [7:0]) for exactly one cycle after acceptance. Data bit i goes to the line named by a 5-bit selector at bits [9+5i+4 : 9+5i]: bit 7 uses [48:44] and bit 0 uses [13:9]. Bit 8 is ignored. A line named by several selectors is high if any of those data bits is 1.
- R6: Opcode 111 keeps all lines at 0 for `CLKS_PER_SEC` cycles after acceptance. It then drives the same byte pattern as R5 for `CLKS_PER_SEC` cycles.
- R7: Opcode 010 produces one `res_valid` cycle in the cycle after acceptance. In that cycle `res_data[i]` equals the input line named by selector i, using the layout of R5.
- R8: A command presented while `busy` is high is discarded. Opcodes 101 and 110, and opcodes 000 and 001 with a count of 0, are ignored: `busy` stays low and no line changes.
- R9: When any hold period ends, every line returns to 0. Whenever `busy` is low, `pin_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_word | input | 52 | Command: opcode, selectors, count or data |
| pin_in | input | 32 | Input lines to be sampled |
| pin_out | output | 32 | Registered output lines |
| busy | output | 1 | A command is executing; new commands are dropped |
| res_valid | output | 1 | One-cycle strobe for a read result |
| res_data | output | 8 | Read result |

## Verification
The assertions take for granted that `CLKS_PER_SEC` is at least 1. They also assume that a command presented during a hold either matters only through being dropped or arrives at the hold's final cycle. Result checks assume that `pin_in` is steady in the cycle a read samples it. The stimulus therefore keeps the input pattern fixed for the length of each read and waits for `busy` to fall before the next command. It breaks that rhythm only in the deliberate drop test, which presents a second command in the middle of a long pulse.

// File: rtl/pin_cmd_pkg.sv
package pin_cmd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_HOLD,
        ST_RDLY
    } exec_state_e;

    localparam int CMD_W   = 52;
    localparam int OP_W    = 3;
    localparam int SEL_W   = 5;
    localparam int LANES   = 8;
    localparam int CNT_W   = 44;
    localparam int SELS_LO = 9;
    localparam int SELS_W  = SEL_W * LANES;
    localparam int NPINS   = 1 << SEL_W;

    localparam logic [OP_W-1:0] OP_PULSE       = 3'b000;
    localparam logic [OP_W-1:0] OP_PULSE_DLY   = 3'b001;
    localparam logic [OP_W-1:0] OP_RD_BYTE     = 3'b010;
    localparam logic [OP_W-1:0] OP_WR_BYTE     = 3'b011;
    localparam logic [OP_W-1:0] OP_RD_BIT      = 3'b100;
    localparam logic [OP_W-1:0] OP_WR_BYTE_DLY = 3'b111;
endpackage

// File: rtl/pin_byte_scatter.sv
module pin_byte_scatter #(
    parameter int SEL_W = 5,
    parameter int LANES = 8,
    localparam int NPINS = 1 << SEL_W
) (
    input  logic [SEL_W*LANES-1:0] sels,
    input  logic [LANES-1:0]       val,
    output logic [NPINS-1:0]       pattern
);
    for (genvar j = 0; j < NPINS; j++) begin : g_pin
        always_comb begin
            pattern[j] = 1'b0;
            for (int i = 0; i < LANES; i++) begin
                if (val[i] && (sels[i*SEL_W +: SEL_W] == SEL_W'(j))) begin
                    pattern[j] = 1'b1;
                end
            end
        end
    end

    always_comb begin
        AST_SCATTER_COUNT: assert ($countones(pattern) <= $countones(val)); // R5
    end
endmodule

// File: rtl/pin_byte_gather.sv
module pin_byte_gather #(
    parameter int SEL_W = 5,
    parameter int LANES = 8,
    localparam int NPINS = 1 << SEL_W
) (
    input  logic [SEL_W*LANES-1:0] sels,
    input  logic [NPINS-1:0]       lines,
    output logic [LANES-1:0]       bits
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign bits[i] = lines[sels[i*SEL_W +: SEL_W]];
    end
endmodule

// File: rtl/pin_cmd_exec.sv
module pin_cmd_exec
    import pin_cmd_pkg::*;
#(
    parameter int unsigned CLKS_PER_SEC = 100_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [51:0]       cmd_word,
    input  logic [31:0]       pin_in,
    output logic [31:0]       pin_out,
    output logic              busy,
    output logic              res_valid,
    output logic [7:0]        res_data
);
    localparam logic [CNT_W-1:0] SEC_M1 = CNT_W'(CLKS_PER_SEC - 1);

    typedef struct packed {
        exec_state_e        st;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   hold;
        logic [NPINS-1:0]   pat;
        logic [NPINS-1:0]   pins;
        logic [SELS_W-1:0]  sels;
        logic               rd_byte;
        logic               rvalid;
        logic [LANES-1:0]   rdata;
    } exec_t;

    exec_t exec_d, exec_q;

    logic [OP_W-1:0]   op;
    logic [CNT_W-1:0]  aux;
    logic [SELS_W-1:0] cmd_sels;
    logic              aux_nz;
    logic              pulse_op;
    logic [LANES-1:0]  scat_val;
    logic [NPINS-1:0]  scat_pat;
    logic [LANES-1:0]  gath_bits;

    assign op       = cmd_word[CMD_W-1 -: OP_W];
    assign aux      = cmd_word[CNT_W-1:0];
    assign cmd_sels = cmd_word[SELS_LO +: SELS_W];
    assign aux_nz   = (aux != '0);
    assign pulse_op = (op == OP_PULSE) || (op == OP_PULSE_DLY);
    assign scat_val = pulse_op ? LANES'(1 << (LANES - 1)) : cmd_word[LANES-1:0];

    pin_byte_scatter #(.SEL_W(SEL_W), .LANES(LANES)) u_scatter (
        .sels    (cmd_sels),
        .val     (scat_val),
        .pattern (scat_pat)
    );

    pin_byte_gather #(.SEL_W(SEL_W), .LANES(LANES)) u_gather (
        .sels  (exec_q.sels),
        .lines (pin_in),
        .bits  (gath_bits)
    );

    always_comb begin
        exec_d        = exec_q;
        exec_d.rvalid = 1'b0;
        unique case (exec_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    case (op)
                        OP_PULSE: if (aux_nz) begin
                            exec_d.pins = scat_pat;
                            exec_d.cnt  = aux - 1'b1;
                            exec_d.st   = ST_HOLD;
                        end
                        OP_PULSE_DLY: if (aux_nz) begin
                            exec_d.pat  = scat_pat;
                            exec_d.hold = aux - 1'b1;
                            exec_d.cnt  = SEC_M1;
                            exec_d.st   = ST_WAIT;
                        end
                        OP_WR_BYTE: begin
                            exec_d.pins = scat_pat;
                            exec_d.cnt  = '0;
                            exec_d.st   = ST_HOLD;
                        end
                        OP_WR_BYTE_DLY: begin
                            exec_d.pat  = scat_pat;
                            exec_d.hold = SEC_M1;
                            exec_d.cnt  = SEC_M1;
                            exec_d.st   = ST_WAIT;
                        end
                        OP_RD_BIT: begin
                            exec_d.sels    = cmd_sels;
                            exec_d.rd_byte = 1'b0;
                            exec_d.cnt     = aux;
                            exec_d.st      = ST_RDLY;
                        end
                        OP_RD_BYTE: begin
                            exec_d.sels    = cmd_sels;
                            exec_d.rd_byte = 1'b1;
                            exec_d.cnt     = '0;
                            exec_d.st      = ST_RDLY;
                        end
                        default: ;
                    endcase
                end
            end
            ST_WAIT: begin
                if (exec_q.cnt == '0) begin
                    exec_d.pins = exec_q.pat;
                    exec_d.cnt  = exec_q.hold;
                    exec_d.st   = ST_HOLD;
                end else begin
                    exec_d.cnt = exec_q.cnt - 1'b1;
                end
            end
            ST_HOLD: begin
                if (exec_q.cnt == '0) begin
                    exec_d.pins = '0;
                    exec_d.st   = ST_IDLE;
                end else begin
                    exec_d.cnt = exec_q.cnt - 1'b1;
                end
            end
            ST_RDLY: begin
                if (exec_q.cnt == '0) begin
                    exec_d.rvalid = 1'b1;
                    exec_d.rdata  = exec_q.rd_byte ? gath_bits
                                                   : {{(LANES-1){1'b0}}, gath_bits[LANES-1]};
                    exec_d.st     = ST_IDLE;
                end else begin
                    exec_d.cnt = exec_q.cnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exec_q <= '0;
        end else begin
            exec_q <= exec_d;
        end
    end

    assign pin_out   = exec_q.pins;
    assign busy      = (exec_q.st != ST_IDLE);
    assign res_valid = exec_q.rvalid;
    assign res_data  = exec_q.rdata;

    AST_IDLE_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (pin_out == '0)); // R9
    AST_RES_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R4
    AST_RES_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !busy && $past(busy)); // R7
    AST_PULSE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && op == OP_PULSE && aux_nz) |=> (busy && pin_out != '0)); // R2
    AST_DROP_WHILE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && exec_q.st == ST_HOLD && exec_q.cnt != '0) |=> $stable(pin_out)); // R8
    AST_IGNORE_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && (op == 3'b101 || op == 3'b110)) |=> !busy); // R8
endmodule

// File: tb/pin_cmd_exec_test.sv
`timescale 1ns/1ps
module pin_cmd_exec_test;
    localparam int CPS = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [51:0] cmd_word = '0;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic        busy;
    logic        res_valid;
    logic [7:0]  res_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pin_cmd_exec #(.CLKS_PER_SEC(CPS)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .pin_in(pin_in), .pin_out(pin_out), .busy(busy),
        .res_valid(res_valid), .res_data(res_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [51:0] one_word(input logic [2:0] op, input logic [4:0] sel,
                                             input logic [43:0] n);
        return {op, sel, n};
    endfunction

    function automatic logic [51:0] byte_word(input logic [2:0] op, input logic [39:0] sels,
                                              input logic [7:0] val);
        return {op, sels, 1'b1, val};
    endfunction

    function automatic logic [31:0] scatter(input logic [39:0] sels, input logic [7:0] val);
        logic [31:0] p = '0;
        for (int i = 0; i < 8; i++) if (val[i]) p[sels[5*i +: 5]] = 1'b1;
        return p;
    endfunction

    function automatic logic [7:0] gather(input logic [39:0] sels, input logic [31:0] lines);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[i] = lines[sels[5*i +: 5]];
        return b;
    endfunction

    function automatic logic [39:0] mk_sels(input int base);
        logic [39:0] s;
        for (int i = 0; i < 8; i++) s[5*i +: 5] = 5'((base * 3 + i * 5 + i * i) % 32);
        return s;
    endfunction

    // Present a word; returns at the falling edge after the acceptance edge (m = 0).
    task automatic send(input logic [51:0] w);
        @(negedge clk);
        cmd_word  = w;
        cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic watch(input string tag, input logic [31:0] pat, input int start, input int len);
        for (int m = 0; m <= start + len; m++) begin
            if (m > 0) @(negedge clk);
            chk(tag, pin_out, (m >= start && m < start + len) ? pat : 32'h0);
            chk({tag, " busy"}, {31'b0, busy}, {31'b0, m < start + len});
        end
    endtask

    task automatic read_bit(input logic [4:0] sel, input int d);
        send(one_word(3'b100, sel, 44'(d)));
        for (int m = 0; m <= d + 1; m++) begin
            if (m > 0) @(negedge clk);
            chk("R4 valid", {31'b0, res_valid}, {31'b0, m == d + 1});
        end
        chk("R4 data", {24'b0, res_data}, {31'b0, pin_in[sel]});
        @(negedge clk);
        chk("R4 single", {31'b0, res_valid}, 32'h0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 pins in reset", pin_out, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pins", pin_out, 32'h0);
        chk("R1 busy", {31'b0, busy}, 32'h0);
        chk("R1 valid", {31'b0, res_valid}, 32'h0);

        for (int l = 0; l < 32; l++) begin
            send(one_word(3'b000, 5'(l), 44'((l % 4) + 1)));
            watch("R2 pulse", 32'h1 << l, 0, (l % 4) + 1);
        end

        for (int l = 0; l < 32; l += 7) begin
            send(one_word(3'b001, 5'(l), 44'((l % 3) + 1)));
            watch("R3 delayed pulse", 32'h1 << l, CPS, (l % 3) + 1);
        end

        pin_in = 32'hA5C3_1E96;
        for (int l = 0; l < 32; l++) read_bit(5'(l), l % 3);
        pin_in = ~pin_in;
        for (int l = 0; l < 32; l += 3) read_bit(5'(l), 5);

        for (int b = 0; b < 16; b++) begin
            logic [39:0] s = mk_sels(b);
            logic [7:0] v = 8'(b * 37 + 11);
            send(byte_word(3'b011, s, v));
            watch("R5 byte write", scatter(s, v), 0, 1);
        end
        send(byte_word(3'b011, {8{5'd5}}, 8'h10));
        watch("R5 overlap", 32'h20, 0, 1);
        send(byte_word(3'b011, {8{5'd5}}, 8'hFF));
        watch("R5 overlap all", 32'h20, 0, 1);
        send(byte_word(3'b011, {5'd31, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd0}, 8'h81));
        watch("R5 lane order", 32'h8000_0001, 0, 1);

        for (int b = 3; b < 6; b++) begin
            logic [39:0] s = mk_sels(b);
            logic [7:0] v = 8'(b * 53 + 7);
            send(byte_word(3'b111, s, v));
            watch("R6 delayed byte", scatter(s, v), CPS, CPS);
        end

        for (int b = 0; b < 16; b++) begin
            logic [39:0] s = mk_sels(b);
            pin_in = 32'h1 << b | 32'h0F0F_0000 ^ (32'(b) << 8);
            send(byte_word(3'b010, s, 8'h00));
            chk("R7 not yet", {31'b0, res_valid}, 32'h0);
            @(negedge clk);
            chk("R7 valid", {31'b0, res_valid}, 32'h1);
            chk("R7 data", {24'b0, res_data}, {24'b0, gather(s, pin_in)});
        end

        // R8: a command while busy is dropped
        send(one_word(3'b000, 5'd3, 44'd6));
        send(one_word(3'b000, 5'd9, 44'd2));
        for (int m = 2; m <= 8; m++) begin
            if (m > 2) @(negedge clk);
            chk("R8 drop", pin_out, (m < 6) ? 32'h8 : 32'h0);
        end
        chk("R8 drop busy", {31'b0, busy}, 32'h0);

        send(one_word(3'b101, 5'd4, 44'd5));
        chk("R8 op101 busy", {31'b0, busy}, 32'h0);
        chk("R8 op101 pins", pin_out, 32'h0);
        send(one_word(3'b110, 5'd4, 44'd5));
        chk("R8 op110 busy", {31'b0, busy}, 32'h0);
        send(one_word(3'b000, 5'd4, 44'd0));
        chk("R8 zero pulse busy", {31'b0, busy}, 32'h0);
        chk("R8 zero pulse pins", pin_out, 32'h0);
        send(one_word(3'b001, 5'd4, 44'd0));
        @(negedge clk);
        chk("R8 zero delayed busy", {31'b0, busy}, 32'h0);

        send(one_word(3'b000, 5'd17, 44'd2));
        watch("R9 after ignored", 32'h1 << 17, 0, 2);
        @(negedge clk);
        chk("R9 idle low", pin_out, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule